// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It has a two-stage pipeline and no idle cycle on the data bus between a read and a write. A command (address, read or write, byte strobes) is captured on a clock edge when clock enable and the load strobe are both low.

Read data sits in an output register one edge later. Write data is taken one edge after that. Both directions therefore use the same bus slot for a given command, and reads and writes can alternate on every clock. A read that follows a write still in flight to the same word returns the new data, merged lane by lane. After a load, holding the load strobe high continues a four-beat burst from an internal counter.

Clock enable freezes the whole pipeline. A sleep input, after a two-cycle entry delay, stops all activity and keeps all state intact. A two-cycle delay also applies on wake-up. The bidirectional bus is split into a data input, a data output and a drive-enable output. The drive enable is never active while the host owns the bus.

Top module: `zbt_sram`

## Requirements
- R1: A read captured on enabled edge k (cke_ni low, adv_ni low, ce_i high, we_ni high) presents the word on rdata_o, with dq_oe_o high, from enabled edge k+1 until the next enabled edge. This holds while oe_ni is low.
- R2: A write captured on enabled edge k samples wdata_i on enabled edge k+2. For each lane l (bits 9l+8 down to 9l), bw_ni[l] low at edge k stores that lane. Lanes with bw_ni[l] high keep their old contents.
- R3: A write with bw_ni equal to 4'b1111 changes no stored bit.
- R4: Commands may alternate read and write on consecutive edges. A read captured one edge after a write to the same address returns the write data in the written lanes and the old data in the others.
- R5: On an edge with cke_ni high, no command is captured, no write is committed, and rdata_o and dq_oe_o keep their values.
- R6: ce_i low with adv_ni low is a deselect, and its bus slot has dq_oe_o low. adv_ni high after a deselect stays deselected, whatever ce_i is.
- R7: adv_ni high after a read or write continues the same operation at the next burst address. With BURST_INTERLEAVE=0, the two low address bits of beat n are (start + n) mod 4, wrapping after four beats. With BURST_INTERLEAVE=1 they are start XOR n.
- R8: oe_ni high forces dq_oe_o low combinationally, at any time.
- R9: dq_oe_o is low in every slot that carries write data.
- R10: sleep_i high sampled on edge e stops command capture and write commit from edge e+2, and holds dq_oe_o low from edge e+1. sleep_i low sampled on edge w restores operation from edge w+2. Stored data and pipeline state survive sleep.
- R11: rst_ni low empties the pipeline and drives dq_oe_o low. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_ni | input | 1 | Active-low clock enable |
| ce_i | input | 1 | Combined chip select, active high |
| adv_ni | input | 1 | Low: load new command; high: continue |
| we_ni | input | 1 | Active-low write enable |
| bw_ni | input | 4 | Active-low byte lane strobes |
| addr_i | input | AW | Word address |
| oe_ni | input | 1 | Active-low asynchronous output enable |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | 36 | Write data (host-driven bus slot) |
| rdata_o | output | 36 | Read data register |
| dq_oe_o | output | 1 | Bus drive enable for rdata_o |

## Verification
Most internal faults surface in the bus slot one or two edges after the command that triggers them. If a stage valid bit is lost or misrouted, dq_oe_o is wrong in that slot. If the burst counter or the captured address is corrupted, the wrong word appears in the next slot. A missing write-data bypass, or a lane decoded wrongly, shows immediately in a back-to-back read of the same address. A write committed at the wrong edge only shows at the next read of that address, so every write test ends with a readback.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [LANES-1:0] bw_n;
  } op_t;
endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen #(
  parameter int AW = 8,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          issue_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o
);
  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, nxt_cnt, nxt_low;

  assign nxt_cnt = cnt_q + 2'd1;

  // R7 burst order variant
  generate
    if (INTERLEAVE) begin : g_ilv
      assign nxt_low = base_q[1:0] ^ nxt_cnt;
    end else begin : g_lin
      assign nxt_low = base_q[1:0] + nxt_cnt;
    end
  endgenerate

  assign issue_o = load_i ? sel_i  : act_q;
  assign wr_o    = load_i ? wr_i   : wr_q;
  assign addr_o  = load_i ? addr_i : {base_q[AW-1:2], nxt_low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      if (load_i) begin
        act_q <= sel_i;
        wr_q  <= wr_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && load_i) base_q <= addr_i;
  end
endmodule

// File: rtl/zbt_mem.sv
module zbt_mem
  import zbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  // one storage column per lane keeps each write port single-driver
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] col_mem [DEPTH];
      always_ff @(posedge clk_i) begin
        if (wbe_i[l]) col_mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
      assign rdata_o[l*LANE_W +: LANE_W] = col_mem[raddr_i];
    end
  endgenerate
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter bit BURST_INTERLEAVE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              ce_i,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic [3:0]        bw_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [35:0]       wdata_i,
  output logic [35:0]       rdata_o,
  output logic              dq_oe_o
);
  logic zz_q, asleep_q, active;

  // R10 two-edge entry and exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zz_q     <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      zz_q     <= sleep_i;
      asleep_q <= zz_q;
    end
  end

  // R5 R10 single enable freezes every pipeline register
  assign active = !cke_ni && !asleep_q;

  logic          iss_vld, iss_wr;
  logic [AW-1:0] iss_addr;

  zbt_burst_gen #(.AW(AW), .INTERLEAVE(BURST_INTERLEAVE)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (active),
    .load_i  (!adv_ni),
    .sel_i   (ce_i),
    .wr_i    (!we_ni),
    .addr_i  (addr_i),
    .issue_o (iss_vld),
    .wr_o    (iss_wr),
    .addr_o  (iss_addr)
  );

  op_t           s1_q, s2_q, iss;
  logic [AW-1:0] a1_q, a2_q;

  assign iss = '{vld: iss_vld, wr: iss_wr, bw_n: bw_ni};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (active) begin
      s1_q <= iss;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (active) begin
      a1_q <= iss_addr;
      a2_q <= a1_q;
    end
  end

  // R2 R3 commit of the write in stage 2 with live bus data
  logic [LANES-1:0]  wbe;
  logic [WORD_W-1:0] mem_rd, rd_word;

  assign wbe = {LANES{active && s2_q.vld && s2_q.wr}} & ~s2_q.bw_n;

  zbt_mem #(.AW(AW)) u_mem (
    .clk_i   (clk_i),
    .wbe_i   (wbe),
    .waddr_i (a2_q),
    .wdata_i (wdata_i),
    .raddr_i (a1_q),
    .rdata_o (mem_rd)
  );

  // R4 lane-wise bypass of the write committing on the same edge
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_byp
      logic hit;
      assign hit = s2_q.vld && s2_q.wr && !s2_q.bw_n[l] && (a2_q == a1_q);
      assign rd_word[l*LANE_W +: LANE_W] = hit ? wdata_i[l*LANE_W +: LANE_W]
                                               : mem_rd[l*LANE_W +: LANE_W];
    end
  endgenerate

  logic              rd_vld_q;
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q <= 1'b0;
      rdata_q  <= '0;
    end else if (active) begin
      rd_vld_q <= s1_q.vld && !s1_q.wr;
      if (s1_q.vld && !s1_q.wr) rdata_q <= rd_word;
    end
  end

  assign rdata_o = rdata_q;
  // R8 R9 R10 bus drive only in read slots
  assign dq_oe_o = rd_vld_q && !oe_ni && !asleep_q;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cke_ni,
  input logic        ce_i,
  input logic        adv_ni,
  input logic        oe_ni,
  input logic [35:0] rdata_o,
  input logic        dq_oe_o,
  input logic        asleep_q,
  input logic        s1_vld,
  input logic        s1_wr,
  input logic        s2_vld,
  input logic        s2_wr
);
  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_q |-> !dq_oe_o);

  // R9
  wr_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld && s2_wr) |-> !dq_oe_o);

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(rdata_o) && $stable(s1_vld) && $stable(s1_wr)));

  // R6
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep_q && !adv_ni && !ce_i) |=> !s1_vld);

  // R1
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep_q && s1_vld && !s1_wr) |=> (oe_ni || asleep_q || dq_oe_o));
endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_ni   (cke_ni),
  .ce_i     (ce_i),
  .adv_ni   (adv_ni),
  .oe_ni    (oe_ni),
  .rdata_o  (rdata_o),
  .dq_oe_o  (dq_oe_o),
  .asleep_q (asleep_q),
  .s1_vld   (s1_q.vld),
  .s1_wr    (s1_q.wr),
  .s2_vld   (s2_q.vld),
  .s2_wr    (s2_q.wr)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0, ce_i = 1'b0, adv_ni = 1'b0, we_ni = 1'b1;
  logic [3:0]    bw_ni = 4'hf;
  logic [AW-1:0] addr_i = '0;
  logic          oe_ni = 1'b0, sleep_i = 1'b0;
  logic [35:0]   wdata_i = '0;
  logic [35:0]   rdata_o;
  logic          dq_oe_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  zbt_sram #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_ni(cke_ni), .ce_i(ce_i),
    .adv_ni(adv_ni), .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr_i),
    .oe_ni(oe_ni), .sleep_i(sleep_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change only at the falling edge
  task automatic op(input logic ce, input logic adv_n, input logic we_n,
                    input logic [3:0] bw, input logic [AW-1:0] a, input logic [35:0] wd);
    ce_i = ce; adv_ni = adv_n; we_ni = we_n; bw_ni = bw; addr_i = a; wdata_i = wd;
    @(negedge clk);
  endtask

  task automatic desel(input logic [35:0] wd);  op(1'b0, 1'b0, 1'b1, 4'hf, '0, wd); endtask
  task automatic rd(input logic [AW-1:0] a);    op(1'b1, 1'b0, 1'b1, 4'hf, a, '0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [3:0] bw); op(1'b1, 1'b0, 1'b0, bw, a, '0); endtask
  task automatic cont(input logic [35:0] wd);   op(1'b1, 1'b1, 1'b1, 4'h0, '0, wd); endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [35:0] d);
    wr(a, 4'h0); desel('0); desel(d);
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [35:0] exp);
    rd(a); desel('0);
    chk(req, {35'd0, dq_oe_o}, 36'd1);
    chk(req, rdata_o, exp);
  endtask

  function automatic logic [35:0] pat(input logic [AW-1:0] a);
    return 36'h0A5A50000 | {28'd0, a};
  endfunction

  task automatic t_reset();
    chk("R11 reset oe", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic t_write_read();
    wr_full(8'h10, 36'h123456789);
    rd(8'h10); desel('0);
    chk("R1 read oe", {35'd0, dq_oe_o}, 36'd1);
    chk("R1 R2 read data", rdata_o, 36'h123456789);
    oe_ni = 1'b1; #1;
    chk("R8 oe high", {35'd0, dq_oe_o}, 36'd0);
    oe_ni = 1'b0; #1;
    chk("R8 oe low", {35'd0, dq_oe_o}, 36'd1);
  endtask

  task automatic t_lanes();
    logic [35:0] m;
    m = {9'h000, 9'h1FF, 9'h000, 9'h1FF};
    wr_full(8'h11, 36'h123456789);
    wr(8'h11, 4'b1010); desel('0); desel(36'hABCDEF012);
    rd_check("R2 lanes 0,2", 8'h11, (36'hABCDEF012 & m) | (36'h123456789 & ~m));
  endtask

  task automatic t_abort();
    wr(8'h10, 4'hf); desel('0); desel(36'hFFFFFFFFF);
    rd_check("R3 abort", 8'h10, 36'h123456789);
  endtask

  task automatic t_back_to_back();
    logic [35:0] m3;
    m3 = {9'h1FF, 27'd0};
    wr(8'h20, 4'h0); rd(8'h20);
    chk("R9 write slot", {35'd0, dq_oe_o}, 36'd0);
    desel(36'h0CAFE0001);
    chk("R4 bypass full", rdata_o, 36'h0CAFE0001);
    wr(8'h20, 4'b0111); rd(8'h20); desel(36'hF00000000);
    chk("R4 bypass lane3", rdata_o, (36'hF00000000 & m3) | (36'h0CAFE0001 & ~m3));
    wr_full(8'h30, pat(8'h30)); wr_full(8'h31, pat(8'h31));
    rd(8'h30); wr(8'h32, 4'h0);
    chk("R4 alt read0", rdata_o, pat(8'h30));
    rd(8'h31);
    chk("R9 alt write slot", {35'd0, dq_oe_o}, 36'd0);
    desel(pat(8'h32));
    chk("R4 alt read1", rdata_o, pat(8'h31));
    rd_check("R4 alt written", 8'h32, pat(8'h32));
  endtask

  task automatic t_cke();
    desel('0); rd(8'h10);
    cke_ni = 1'b1;
    wr(8'h10, 4'h0); desel(36'h0DEADBEEF); desel(36'h0DEADBEEF);
    chk("R5 frozen oe", {35'd0, dq_oe_o}, 36'd0);
    cke_ni = 1'b0;
    desel('0);
    chk("R5 resumed read", rdata_o, 36'h123456789);
    rd_check("R5 write ignored", 8'h10, 36'h123456789);
  endtask

  task automatic t_deselect();
    rd(8'h10); desel('0);
    chk("R6 read before", {35'd0, dq_oe_o}, 36'd1);
    op(1'b1, 1'b1, 1'b1, 4'h0, 8'h10, '0);
    chk("R6 deselect slot", {35'd0, dq_oe_o}, 36'd0);
    desel('0);
    chk("R6 continue deselect", {35'd0, dq_oe_o}, 36'd0);
  endtask

  task automatic t_burst();
    wr(8'h42, 4'h0); cont('0); cont(pat(8'h42)); cont(pat(8'h43));
    desel(pat(8'h40)); desel(pat(8'h41));
    rd(8'h41); cont('0);
    chk("R7 beat0", rdata_o, pat(8'h41));
    cont('0);
    chk("R7 beat1", rdata_o, pat(8'h42));
    cont('0);
    chk("R7 beat2", rdata_o, pat(8'h43));
    desel('0);
    chk("R7 beat3 wrap", rdata_o, pat(8'h40));
  endtask

  task automatic t_sleep();
    wr_full(8'h50, 36'h055555555);
    sleep_i = 1'b1;
    rd(8'h50); desel('0);
    chk("R10 asleep oe", {35'd0, dq_oe_o}, 36'd0);
    wr(8'h50, 4'h0); desel(36'h0EEEEEEEE); desel(36'h0EEEEEEEE);
    chk("R10 still asleep", {35'd0, dq_oe_o}, 36'd0);
    sleep_i = 1'b0;
    desel('0); desel('0);
    chk("R10 wake oe", {35'd0, dq_oe_o}, 36'd1);
    chk("R10 wake data", rdata_o, 36'h055555555);
    rd_check("R10 write ignored", 8'h50, 36'h055555555);
  endtask

  task automatic t_reset_mid();
    wr_full(8'h60, 36'h066666666);
    rd(8'h60);
    rst_ni = 1'b0;
    desel('0);
    chk("R11 pipeline cleared", {35'd0, dq_oe_o}, 36'd0);
    rst_ni = 1'b1;
    desel('0); desel('0);
    chk("R11 no stale read", {35'd0, dq_oe_o}, 36'd0);
    rd_check("R11 array kept", 8'h60, 36'h066666666);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_write_read();
    t_lanes();
    t_abort();
    t_back_to_back();
    t_cke();
    t_deselect();
    t_burst();
    t_sleep();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule